// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the register file of a three-operand load-store processor in which procedure calls are handled by sliding a window over a large circular bank, not by saving registers to memory. At any moment software addresses 56 registers through a 6-bit visible number. Thirty-two global registers are always visible. A 24-register window onto a 256-entry windowed bank supplies the rest. The window is divided into three groups of eight: parameters received from the caller, locals, and parameters being handed to a callee.

A call strobe advances the window pointer by one window step of 16 physical registers. A return strobe moves it back. Adjacent windows overlap by one group, so the caller's outgoing group is the same storage as the callee's incoming group. Arguments pass with no copying. A resident-window counter tracks how many windows hold live frames. When a call would exceed the on-chip capacity, or a return would drop the last live window, the strobe is refused and a one-cycle flag tells external logic to spill frames to a memory stack or fill them back. That external logic is not part of this block.

The file has two combinational read ports and one write port that commits on the clock edge.

Top module: `winreg_file`

## Requirements
- R1: Visible numbers 0 to 31 select the global registers; a global holds its value and reads the same whatever the window pointer is.
- R2: With window pointer wp, visible numbers 32 to 39 (incoming), 40 to 47 (local) and 48 to 55 (outgoing) map to physical windowed entry (16*wp + n - 32) mod 256, so the group offsets are 0, 8 and 16.
- R3: An accepted call increments wp, so a value written at visible 48+k before the call reads at visible 32+k after it, and the callee's locals are storage separate from the caller's.
- R4: An accepted return decrements wp, so the caller's locals read back unchanged, and a value the callee wrote at 32+k reads at 48+k in the caller.
- R5: A call made while all 16 windows are resident raises ovf_o in that same cycle and leaves the pointer and the mapping unchanged.
- R6: A return made while only one window is resident raises unf_o in that same cycle and leaves the pointer unchanged.
- R7: Visible numbers 56 to 63 read as zero on both ports, and a write to them changes no register.
- R8: Reads are combinational. A write is committed at the rising clock edge, so a read of the register being written in the same cycle returns the old value, and the new value appears after the edge.
- R9: Reset (rst_n low) sets wp to 0 and the resident count to one window. It does not clear register contents. A return issued right after reset therefore underflows.
- R10: When call_i and ret_i are both high in one cycle, the pointer does not move and neither flag is raised.
- R11: The two read ports select their registers independently in the same cycle.
- R12: The bank is circular. The outgoing group of window 15 is the same storage as the incoming group of window 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of pointer and counter |
| rd_addr_a | input | 6 | Visible register number, read port A |
| rd_data_a | output | 32 | Read data, port A (combinational) |
| rd_addr_b | input | 6 | Visible register number, read port B |
| rd_data_b | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Visible register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Call strobe, advances the window |
| ret_i | input | 1 | Return strobe, retreats the window |
| ovf_o | output | 1 | Call refused because all windows are resident |
| unf_o | output | 1 | Return refused because only one window is resident |

## Verification
The bench builds the block with its default parameters: 32 globals, groups of eight and 16 windows, with 32-bit data. Sixteen windows are few enough that fifteen back-to-back calls fill the bank. One more call then reaches the overflow refusal, and the pointer reaches 15, where the outgoing group wraps onto window 0's incoming group. Unwinding the same nest reaches the underflow refusal. The bench keeps its own copy of the bank, addressed by its own window arithmetic, and compares every read against it.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;

  // Physical index of a visible register number for window pointer wp.
  function automatic int unsigned map_phys(input int unsigned vaddr,
                                           input int unsigned wp,
                                           input int unsigned ngl,
                                           input int unsigned grp,
                                           input int unsigned nwin);
    int unsigned span;
    if (vaddr < ngl) return vaddr;
    span = nwin * 2 * grp;
    return ngl + ((wp * 2 * grp + (vaddr - ngl)) % span);
  endfunction

  // Number of visible registers: globals plus three groups.
  function automatic int unsigned visible_count(input int unsigned ngl,
                                                input int unsigned grp);
    return ngl + 3 * grp;
  endfunction

endpackage

// File: rtl/rwf_map.sv
`timescale 1ns/1ps
module rwf_map #(
  parameter int NGLOB = 32,
  parameter int GRP   = 8,
  parameter int NWIN  = 16,
  parameter int VA_W  = 6,
  parameter int WP_W  = 4,
  parameter int PI_W  = 9
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [WP_W-1:0] wp,
  output logic [PI_W-1:0] pidx,
  output logic            valid
);
  localparam int VIS  = NGLOB + 3 * GRP;
  localparam int PHYS = NGLOB + NWIN * 2 * GRP;

  assign valid = 32'(vaddr) < rwf_pkg::visible_count(NGLOB, GRP);
  assign pidx  = PI_W'(rwf_pkg::map_phys(32'(vaddr), 32'(wp), NGLOB, GRP, NWIN));

  // R2: every valid visible number lands inside the physical bank
  always_comb begin
    if (valid) begin
      a_r2_idx_range: assert (32'(pidx) < PHYS);
    end
  end
endmodule

// File: rtl/rwf_ptr.sv
`timescale 1ns/1ps
module rwf_ptr #(
  parameter int NWIN = 16,
  parameter int WP_W = 4,
  parameter int RES_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [WP_W-1:0] wp,
  output logic            ovf,
  output logic            unf
);
  logic [RES_W-1:0] res_q;
  logic [WP_W-1:0]  wp_q;

  logic call_only, ret_only, full, single, advance, retreat;

  assign call_only = call_i & ~ret_i;
  assign ret_only  = ret_i & ~call_i;
  assign full      = (res_q == RES_W'(NWIN));
  assign single    = (res_q == RES_W'(1));
  assign advance   = call_only & ~full;
  assign retreat   = ret_only & ~single;
  assign ovf       = call_only & full;
  assign unf       = ret_only & single;
  assign wp        = wp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      res_q <= RES_W'(1);
    end else if (advance) begin
      wp_q  <= wp_q + 1'b1;
      res_q <= res_q + 1'b1;
    end else if (retreat) begin
      wp_q  <= wp_q - 1'b1;
      res_q <= res_q - 1'b1;
    end
  end

  a_r3_call_advances: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> wp_q == WP_W'($past(wp_q) + 1'b1));

  a_r4_ret_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    retreat |=> wp_q == WP_W'($past(wp_q) - 1'b1));

  a_r5_ovf_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (wp_q == $past(wp_q)) && (res_q == $past(res_q)));

  a_r6_unf_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> (wp_q == $past(wp_q)) && (res_q == $past(res_q)));

  a_r9_res_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q >= RES_W'(1)) && (res_q <= RES_W'(NWIN)));

  a_r10_both_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(wp_q));

  a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

// File: rtl/rwf_bank.sv
`timescale 1ns/1ps
module rwf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 288,
  parameter int AW    = 9,
  parameter int NRD   = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file #(
  parameter int DW    = 32,
  parameter int NGLOB = 32,
  parameter int GRP   = 8,
  parameter int NWIN  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [5:0]    rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [5:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          call_i,
  input  logic          ret_i,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int VA_W  = 6;
  localparam int VIS   = NGLOB + 3 * GRP;
  localparam int PHYS  = NGLOB + NWIN * 2 * GRP;
  localparam int PI_W  = $clog2(PHYS);
  localparam int WP_W  = $clog2(NWIN);
  localparam int RES_W = $clog2(NWIN + 1);
  localparam int NRD   = 2;

  logic [WP_W-1:0]             wp;
  logic [NRD-1:0][VA_W-1:0]    rd_vaddr;
  logic [NRD-1:0][PI_W-1:0]    rd_pidx;
  logic [NRD-1:0]              rd_valid;
  logic [NRD-1:0][DW-1:0]      bank_rdata;
  logic [NRD-1:0][DW-1:0]      port_data;
  logic [PI_W-1:0]             wr_pidx;
  logic                        wr_valid;
  logic                        bank_we;

  assign rd_vaddr[0] = rd_addr_a;
  assign rd_vaddr[1] = rd_addr_b;

  rwf_ptr #(.NWIN(NWIN), .WP_W(WP_W), .RES_W(RES_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .wp(wp), .ovf(ovf_o), .unf(unf_o)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_rmap
    rwf_map #(.NGLOB(NGLOB), .GRP(GRP), .NWIN(NWIN), .VA_W(VA_W),
              .WP_W(WP_W), .PI_W(PI_W)) u_map (
      .vaddr(rd_vaddr[g]), .wp(wp), .pidx(rd_pidx[g]), .valid(rd_valid[g])
    );
    assign port_data[g] = rd_valid[g] ? bank_rdata[g] : '0;
  end

  rwf_map #(.NGLOB(NGLOB), .GRP(GRP), .NWIN(NWIN), .VA_W(VA_W),
            .WP_W(WP_W), .PI_W(PI_W)) u_wmap (
    .vaddr(wr_addr), .wp(wp), .pidx(wr_pidx), .valid(wr_valid)
  );

  assign bank_we = wr_en & wr_valid;

  rwf_bank #(.DW(DW), .DEPTH(PHYS), .AW(PI_W), .NRD(NRD)) u_bank (
    .clk(clk), .we(bank_we), .waddr(wr_pidx), .wdata(wr_data),
    .raddr(rd_pidx), .rdata(bank_rdata)
  );

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];

  a_r7_hi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_addr_a) >= VIS) |-> (rd_data_a == '0));

  a_r7_hi_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_addr) >= VIS)) |-> !bank_we);

  a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && !call_i && !ret_i && (rd_pidx[0] == wr_pidx) && rd_valid[0])
      ##1 (rd_addr_a == $past(rd_addr_a)) && $stable(wp)
      |-> rd_data_a == $past(wr_data));
endmodule

// File: tb/tb_winreg_file.sv
`timescale 1ns/1ps
module tb_winreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic        ovf_o, unf_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] shadow [288];
  int bwp = 0;
  int bres = 1;

  always #10 clk = ~clk;

  winreg_file dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_i(call_i), .ret_i(ret_i), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // Bench view of the mapping: window base advances 16 per step, wraps at 256.
  function automatic int bidx(input int a, input int w);
    if (a < 32) return a;
    return 32 + (((w << 4) + (a - 32)) & 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a < 56) shadow[bidx(a, bwp)] = d;
  endtask

  task automatic rd_chk(input string req, input int a);
    logic [31:0] e;
    @(negedge clk);
    rd_addr_a = 6'(a);
    #1;
    e = (a >= 56) ? 32'h0 : shadow[bidx(a, bwp)];
    check(req, rd_data_a, e);
  endtask

  task automatic do_call(input string req);
    logic exp_ovf;
    @(negedge clk);
    call_i = 1'b1;
    #1;
    exp_ovf = (bres == 16);
    check({req, " ovf"}, 32'(ovf_o), 32'(exp_ovf));
    check({req, " unf"}, 32'(unf_o), 32'h0);
    @(posedge clk); #1;
    call_i = 1'b0;
    if (!exp_ovf) begin bwp = (bwp + 1) % 16; bres++; end
  endtask

  task automatic do_ret(input string req);
    logic exp_unf;
    @(negedge clk);
    ret_i = 1'b1;
    #1;
    exp_unf = (bres == 1);
    check({req, " unf"}, 32'(unf_o), 32'(exp_unf));
    check({req, " ovf"}, 32'(ovf_o), 32'h0);
    @(posedge clk); #1;
    ret_i = 1'b0;
    if (!exp_unf) begin bwp = (bwp + 15) % 16; bres--; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    bwp = 0; bres = 1;
    check("R9 ovf after reset", 32'(ovf_o), 32'h0);
    check("R9 unf after reset", 32'(unf_o), 32'h0);
    do_ret("R9 R6 return at reset underflows");
    wr(40, 32'hA0A0_0001);
    do_ret("R6 second underflow");
    rd_chk("R6 pointer unchanged after underflow", 40);
  endtask

  task automatic t_globals();
    wr(5, 32'h0000_0555);
    wr(31, 32'h3131_3131);
    do_call("R1 call");
    do_call("R1 call");
    rd_chk("R1 global 5 after calls", 5);
    rd_chk("R1 global 31 after calls", 31);
    do_ret("R1 ret");
    do_ret("R1 ret");
    rd_chk("R1 global 5 at wp0", 5);
  endtask

  task automatic t_pass();
    for (int k = 0; k < 8; k++) wr(48 + k, 32'hC0DE_0000 + 32'(k));
    wr(40, 32'h1111_0040);
    wr(47, 32'h1111_0047);
    do_call("R3 call");
    rd_chk("R3 arg 0 visible as incoming", 32);
    rd_chk("R3 arg 7 visible as incoming", 39);
    rd_chk("R2 R3 callee outgoing group", 48);
    wr(40, 32'h2222_0040);
    wr(32, 32'hFEED_0032);
    rd_chk("R3 callee local separate", 40);
    do_ret("R4 ret");
    rd_chk("R4 caller local 40 restored", 40);
    rd_chk("R4 caller local 47 restored", 47);
    rd_chk("R4 callee incoming seen as caller outgoing", 48);
  endtask

  task automatic t_two_ports();
    @(negedge clk);
    rd_addr_a = 6'd5; rd_addr_b = 6'd47;
    #1;
    check("R11 port A", rd_data_a, shadow[bidx(5, bwp)]);
    check("R11 port B", rd_data_b, shadow[bidx(47, bwp)]);
    rd_addr_b = 6'd60;
    #1;
    check("R7 R11 port B high number zero", rd_data_b, 32'h0);
  endtask

  task automatic t_high();
    do_call("R7 call");
    wr(40, 32'h5A5A_1234);
    do_ret("R7 ret");
    wr(56, 32'hDEAD_BEEF);
    wr(63, 32'hDEAD_BEEF);
    rd_chk("R7 read 56 zero", 56);
    rd_chk("R7 read 63 zero", 63);
    do_call("R7 call");
    rd_chk("R7 next window local untouched", 40);
    do_ret("R7 ret");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    rd_addr_a = 6'd41;
    wr_en = 1'b1; wr_addr = 6'd41; wr_data = 32'h7777_0041;
    #1;
    check("R8 same-cycle read returns old", rd_data_a, shadow[bidx(41, bwp)]);
    @(posedge clk); #1;
    wr_en = 1'b0;
    shadow[bidx(41, bwp)] = 32'h7777_0041;
    check("R8 new value after edge", rd_data_a, 32'h7777_0041);
  endtask

  task automatic t_both();
    wr(42, 32'hB0B0_0042);
    @(negedge clk);
    call_i = 1'b1; ret_i = 1'b1;
    #1;
    check("R10 no ovf", 32'(ovf_o), 32'h0);
    check("R10 no unf", 32'(unf_o), 32'h0);
    @(posedge clk); #1;
    call_i = 1'b0; ret_i = 1'b0;
    rd_chk("R10 pointer unmoved", 42);
  endtask

  task automatic t_deep();
    wr(32, 32'h0123_4567);
    for (int i = 0; i < 15; i++) do_call("R5 fill call");
    rd_chk("R12 window 15 outgoing aliases window 0 incoming", 48);
    wr(40, 32'h1515_0040);
    do_call("R5 overflow call");
    rd_chk("R5 pointer unchanged after overflow", 40);
    wr(48, 32'h89AB_CDEF);
    for (int i = 0; i < 15; i++) do_ret("R4 unwind ret");
    rd_chk("R12 wrap write seen in window 0", 32);
    do_ret("R6 underflow after unwind");
  endtask

  initial begin
    t_reset();
    t_globals();
    t_pass();
    t_two_ports();
    t_high();
    t_same_cycle();
    t_both();
    t_deep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule